// File: doc/BRIEF.md
# Bus-Oriented Universal Shift Register

A four-stage register on one clock. A two-bit mode code selects what it does at each rising edge: capture a parallel word, shift towards the high stage, shift towards the low stage, or clear to zero. Each shift direction has its own serial input. Cascading to wider words is done outside the block by wiring a neighbour's end output to the matching serial input.

The stored word leaves through three-state drivers controlled by an output enable. Several of these registers can therefore share one bus. The block has no reset pin. Its contents are unknown after power-up until the first clocked clear or load, and it is fully static: with the clock stopped it keeps its word indefinitely.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode_i = 2'b11, a rising edge of clk_i copies d_i into the register, and q_o shows the new word after that edge.
- R2: During a load (mode_i = 2'b11), ser_r_i and ser_l_i have no effect on the captured word.
- R3: With mode_i = 2'b01, a rising edge shifts towards the high stage: bit i takes bit i-1, and bit 0 takes ser_r_i.
- R4: With mode_i = 2'b10, a rising edge shifts towards the low stage: bit i takes bit i+1, and bit 3 takes ser_l_i.
- R5: With mode_i = 2'b00, a rising edge sets every stage to 0. There is no other way to clear the register, and there is no asynchronous path.
- R6: While oe_i is 0, every bit of q_o is high impedance.
- R7: While oe_i is 1, q_o drives the stored word.
- R8: oe_i affects only the drivers. Clocked loads, shifts and clears carried out while oe_i is 0 still update the stored word, and that word appears when oe_i returns to 1.
- R9: Without a rising edge on clk_i, changes on mode_i, d_i, ser_r_i and ser_l_i leave the stored word unchanged, however long the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every state change happens on its rising edge |
| mode_i | input | 2 | 00 clear, 01 shift towards high stage, 10 shift towards low stage, 11 parallel load |
| d_i | input | 4 | Parallel data word |
| ser_r_i | input | 1 | Serial input entering bit 0 on a shift towards the high stage |
| ser_l_i | input | 1 | Serial input entering bit 3 on a shift towards the low stage |
| oe_i | input | 1 | Output enable; 0 puts q_o in high impedance |
| q_o | output | 4 | Stored word through three-state drivers |

## Verification
The hardest case to reach from the ports is a change to the stored word while oe_i is low, because the word cannot be seen at that time. The bench first floats the bus and checks for high impedance with case equality. It then loads, shifts and clears the register while the bus stays floated, re-enables the drivers, and compares the result against its own model. A second hard case is holding the word with the clock stopped. The bench gates its own clock for a long interval and changes every data and mode input during that interval.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
  import usr_pkg::*;
(
  input  logic      clk_i,
  input  usr_mode_e mode_i,
  input  logic      par_i,
  input  logic      from_lo_i,
  input  logic      from_hi_i,
  output logic      bit_o
);
  always_ff @(posedge clk_i) begin
    case (mode_i)
      MODE_CLEAR: bit_o <= 1'b0;
      MODE_RIGHT: bit_o <= from_lo_i;
      MODE_LEFT:  bit_o <= from_hi_i;
      default:    bit_o <= par_i;
    endcase
  end
endmodule

// File: rtl/usr_tri_driver.sv
module usr_tri_driver #(
  parameter int W = 4
) (
  input  logic         oe_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] pad_o
);
  assign pad_o = oe_i ? val_i : {W{1'bz}};
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] d_i,
  input  logic         ser_r_i,
  input  logic         ser_l_i,
  input  logic         oe_i,
  output logic [W-1:0] q_o
);
  localparam int MSB = W - 1;

  usr_mode_e    mode;
  logic [W-1:0] state_q;
  logic [W-1:0] lo_src;
  logic [W-1:0] hi_src;

  assign mode = usr_mode_e'(mode_i);

  for (genvar i = 0; i < W; i++) begin : g_stage
    // neighbour taps; end stages take the serial inputs
    if (i == 0) begin : g_lo_end
      assign lo_src[i] = ser_r_i;
    end else begin : g_lo_mid
      assign lo_src[i] = state_q[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign hi_src[i] = ser_l_i;
    end else begin : g_hi_mid
      assign hi_src[i] = state_q[i+1];
    end

    usr_bit_cell i_cell (
      .clk_i     (clk_i),
      .mode_i    (mode),
      .par_i     (d_i[i]),
      .from_lo_i (lo_src[i]),
      .from_hi_i (hi_src[i]),
      .bit_o     (state_q[i])
    );
  end

  usr_tri_driver #(.W(W)) i_drv (
    .oe_i  (oe_i),
    .val_i (state_q),
    .pad_o (q_o)
  );
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] d_i,
  input logic         ser_r_i,
  input logic         ser_l_i,
  input logic [W-1:0] state_i
);
  // contents are undefined until the first clear or load
  logic primed = 1'b0;
  always_ff @(posedge clk_i)
    if (mode_i == 2'b00 || mode_i == 2'b11) primed <= 1'b1;

  p_load_r1: assert property (@(posedge clk_i) disable iff (!primed)
    mode_i == 2'b11 |=> state_i == $past(d_i));

  p_shift_hi_r3: assert property (@(posedge clk_i) disable iff (!primed)
    mode_i == 2'b01 |=> state_i == {$past(state_i[W-2:0]), $past(ser_r_i)});

  p_shift_lo_r4: assert property (@(posedge clk_i) disable iff (!primed)
    mode_i == 2'b10 |=> state_i == {$past(ser_l_i), $past(state_i[W-1:1])});

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!primed)
    mode_i == 2'b00 |=> state_i == '0);
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.W(W)) i_chk (
  .clk_i   (clk_i),
  .mode_i  (mode_i),
  .d_i     (d_i),
  .ser_r_i (ser_r_i),
  .ser_l_i (ser_l_i),
  .state_i (state_q)
);

// File: tb/test_usr_shift_reg.sv
module test_usr_shift_reg;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         clk_en = 1'b1;
  logic [1:0]   mode_i = 2'b00;
  logic [W-1:0] d_i = '0;
  logic         ser_r_i = 1'b0;
  logic         ser_l_i = 1'b0;
  logic         oe_i = 1'b1;
  wire  [W-1:0] q_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] model;

  always #10 if (clk_en) clk_i = ~clk_i;

  usr_shift_reg #(.W(W)) i_usr_shift_reg (
    .clk_i, .mode_i, .d_i, .ser_r_i, .ser_l_i, .oe_i, .q_o
  );

  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    n_vec++;
    if (q_o !== exp) begin
      n_bad++;
      $display("FAIL %s: q_o=%b expected %b", req, q_o, exp);
    end
  endtask

  task automatic op(input logic [1:0] m, input logic [W-1:0] d, input logic sr, input logic sl);
    mode_i = m; d_i = d; ser_r_i = sr; ser_l_i = sl;
    tick();
    case (m)
      2'b00: model = '0;
      2'b01: model = {model[W-2:0], sr};
      2'b10: model = {sl, model[W-1:1]};
      default: model = d;
    endcase
  endtask

  task automatic t_clear();
    op(2'b11, 4'b1111, 1'b0, 1'b0);
    op(2'b00, 4'b1010, 1'b1, 1'b1);
    check("R5 clear", 4'b0000);
  endtask

  task automatic t_load();
    op(2'b11, 4'b1001, 1'b1, 1'b1);
    check("R1 load", 4'b1001);
    check("R7 drive", model);
    op(2'b11, 4'b0110, 1'b0, 1'b1);
    check("R2 serial ignored on load", 4'b0110);
    op(2'b11, 4'b0000, 1'b1, 1'b0);
    check("R2 serial ignored on load", 4'b0000);
  endtask

  task automatic t_right();
    op(2'b11, 4'b0000, 1'b0, 1'b0);
    op(2'b01, 4'b1111, 1'b1, 1'b0);
    check("R3 shift high", 4'b0001);
    op(2'b01, 4'b0000, 1'b0, 1'b1);
    check("R3 shift high", 4'b0010);
    op(2'b01, 4'b0000, 1'b1, 1'b0);
    check("R3 shift high", 4'b0101);
    op(2'b01, 4'b0000, 1'b1, 1'b0);
    check("R3 shift high drops bit 3", 4'b1011);
  endtask

  task automatic t_left();
    op(2'b11, 4'b0001, 1'b0, 1'b0);
    op(2'b10, 4'b1111, 1'b0, 1'b1);
    check("R4 shift low drops bit 0", 4'b1000);
    op(2'b10, 4'b0000, 1'b1, 1'b0);
    check("R4 shift low", 4'b0100);
    op(2'b10, 4'b0000, 1'b0, 1'b1);
    check("R4 shift low", 4'b1010);
  endtask

  task automatic t_float();
    op(2'b11, 4'b1100, 1'b0, 1'b0);
    oe_i = 1'b0;
    #2;
    check("R6 high impedance", {W{1'bz}});
    op(2'b01, 4'b0000, 1'b1, 1'b0);
    check("R6 high impedance while shifting", {W{1'bz}});
    op(2'b10, 4'b0000, 1'b0, 1'b1);
    op(2'b01, 4'b0000, 1'b0, 1'b0);
    oe_i = 1'b1;
    #2;
    check("R8 shifts while floated", model);
    oe_i = 1'b0;
    op(2'b00, 4'b1111, 1'b1, 1'b1);
    oe_i = 1'b1;
    #2;
    check("R8 clear while floated", 4'b0000);
    oe_i = 1'b0;
    op(2'b11, 4'b0111, 1'b0, 1'b0);
    oe_i = 1'b1;
    #2;
    check("R8 load while floated", 4'b0111);
  endtask

  task automatic t_hold();
    op(2'b11, 4'b1010, 1'b0, 1'b0);
    @(negedge clk_i);
    clk_en = 1'b0;
    mode_i = 2'b00; d_i = 4'b0101; ser_r_i = 1'b1; ser_l_i = 1'b1;
    #400;
    check("R9 hold, clock stopped", 4'b1010);
    mode_i = 2'b11;
    #400;
    check("R9 hold, clock stopped", 4'b1010);
    mode_i = 2'b01;
    clk_en = 1'b1;
    tick();
    model = {4'b1010 << 1} | 4'b0001;
    check("R3 shift after restart", model);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_clear();
    t_load();
    t_right();
    t_left();
    t_float();
    t_hold();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule